// File: doc/BRIEF.md
# Rate-Paced Digital Pin Streamer

This block connects a processor bus to a bank of general-purpose digital pins through two FIFOs. Both directions run at one user-programmed rate. A pacing counter makes a single-cycle tick once every `divider + 1` clock cycles. On each tick, the synchronized pin levels are pushed into the receive FIFO. On the same tick, one word is popped from the transmit FIFO and driven onto the pins.

The processor reaches the block through a small register port. It can read the receive FIFO and write the transmit FIFO at one word per clock, whatever the pin rate is. A direction register sets each pin as an input or an output, and it can be changed while streaming. Sticky flags record when a tick found the receive FIFO full or the transmit FIFO empty. The pacing logic is a separate module, so a second FIFO pair, such as an analog sample path, can use it.

Top module: `dio_stream`

## Requirements
- R1: After reset, `pin_o` and `pin_oe_o` are zero, enable and divider are zero, the direction register is all inputs, and both sticky flags are clear.
- R2: While enable (CTRL bit 0, address 0) is set, a tick occurs once every DIV+1 cycles, where DIV is the 16-bit value at address 1. While enable is clear, the counter is held at zero and neither FIFO is pushed or popped by the pin side.
- R3: Each pin passes through two synchronizer flops. On a tick, the sampled word is pushed into the receive FIFO. A bit whose direction bit is 0 carries the synchronized pin level, and a bit whose direction bit is 1 reads 0.
- R4: A tick that finds the receive FIFO full drops the sample and sets STATUS bit 0 (address 3). The bit stays set until the bus writes 1 to it. A set in the same cycle as the clear wins.
- R5: On a tick with a word in the transmit FIFO, that word is popped and drives `pin_o` from the next cycle. `pin_oe_o` equals the direction register at address 2, where 1 means output.
- R6: A tick that finds the transmit FIFO empty leaves `pin_o` unchanged and sets STATUS bit 1. The bit is cleared by writing 1 to it, and a set in the same cycle wins.
- R7: A bus read at address 4 returns the oldest receive word and pops it, one word per cycle, regardless of ticks. When the FIFO is empty, the read returns 0 and pops nothing.
- R8: A bus write at address 5 pushes into the transmit FIFO. The write is dropped when the FIFO is full.
- R9: Reads return enable at address 0, the divider at address 1, and direction at address 2. Address 3 gives the overflow flag in bit 0, the underflow flag in bit 1, receive-empty in bit 2 and transmit-full in bit 3. Address 6 gives the receive level in bits 7:0 and the transmit level in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| pin_i | input | 12 | Pin levels from the pads |
| pin_o | output | 12 | Driven pin levels |
| pin_oe_o | output | 12 | Per-pin output enable |

## Verification
The hardest case to reach is a tick that coincides with a bus event: a flag clear, a receive pop when the FIFO is full, or a direction change in the cycle a sample is taken. These only line up when the divider is small. The stimulus sets the divider to zero, which makes a tick every cycle. It then fills the receive FIFO to overflow, overfills the transmit FIFO while paused, and rewrites the direction and clears the flags mid-stream. A behavioural model is checked against the pins and the read data on every clock.

// File: rtl/dio_stream_pkg.sv
package dio_stream_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_DIV  = 3'd1,
    REG_DIR  = 3'd2,
    REG_STAT = 3'd3,
    REG_RXD  = 3'd4,
    REG_TXD  = 3'd5,
    REG_LVL  = 3'd6
  } reg_addr_e;

  localparam int STAT_OVF = 0;
  localparam int STAT_UNF = 1;
  localparam int STAT_RXE = 2;
  localparam int STAT_TXF = 3;
endpackage

// File: rtl/pace_tick_gen.sv
module pace_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     st_q[s] <= '0;
        else if (s == 0) st_q[s] <= d_i;
        else             st_q[s] <= st_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dio_stream.sv
module dio_stream
  import dio_stream_pkg::*;
#(
  parameter int PIN_W      = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16,
  parameter int BUS_W      = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic [PIN_W-1:0] pin_i,
  output logic [PIN_W-1:0] pin_o,
  output logic [PIN_W-1:0] pin_oe_o
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic             en_q, ovf_q, unf_q;
  logic [DIV_W-1:0] div_q, cnt;
  logic [PIN_W-1:0] dir_q, drive_q, pin_s;
  logic             tick, wr, rd, clr_ovf, clr_unf;
  logic [PIN_W-1:0] rx_rdata, tx_rdata;
  logic             rx_full, rx_empty, tx_full, tx_empty, rx_pop, tx_push;
  logic [CW-1:0]    rx_cnt, tx_cnt;

  assign wr      = cs_i && we_i;
  assign rd      = cs_i && !we_i;
  assign clr_ovf = wr && (addr_i == REG_STAT) && wdata_i[STAT_OVF];
  assign clr_unf = wr && (addr_i == REG_STAT) && wdata_i[STAT_UNF];
  assign rx_pop  = rd && (addr_i == REG_RXD);
  assign tx_push = wr && (addr_i == REG_TXD);

  pace_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .div_i(div_q),
    .tick_o(tick), .cnt_o(cnt)
  );

  pin_sync #(.W(PIN_W), .STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  sync_fifo #(.W(PIN_W), .DEPTH(FIFO_DEPTH)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(tick), .wdata_i(pin_s & ~dir_q),
    .pop_i(rx_pop), .rdata_o(rx_rdata),
    .full_o(rx_full), .empty_o(rx_empty), .count_o(rx_cnt)
  );

  sync_fifo #(.W(PIN_W), .DEPTH(FIFO_DEPTH)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(tx_push), .wdata_i(wdata_i[PIN_W-1:0]),
    .pop_i(tick), .rdata_o(tx_rdata),
    .full_o(tx_full), .empty_o(tx_empty), .count_o(tx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      div_q   <= '0;
      dir_q   <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      drive_q <= '0;
    end else begin
      if (wr && addr_i == REG_CTRL) en_q  <= wdata_i[0];
      if (wr && addr_i == REG_DIV)  div_q <= wdata_i[DIV_W-1:0];
      if (wr && addr_i == REG_DIR)  dir_q <= wdata_i[PIN_W-1:0];
      // a new event outranks a same-cycle clear
      ovf_q <= (ovf_q && !clr_ovf) || (tick && rx_full);
      unf_q <= (unf_q && !clr_unf) || (tick && tx_empty);
      if (tick && !tx_empty) drive_q <= tx_rdata;
    end
  end

  assign pin_o    = drive_q;
  assign pin_oe_o = dir_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: rdata_o[0] = en_q;
      REG_DIV:  rdata_o[DIV_W-1:0] = div_q;
      REG_DIR:  rdata_o[PIN_W-1:0] = dir_q;
      REG_STAT: begin
        rdata_o[STAT_OVF] = ovf_q;
        rdata_o[STAT_UNF] = unf_q;
        rdata_o[STAT_RXE] = rx_empty;
        rdata_o[STAT_TXF] = tx_full;
      end
      REG_RXD:  rdata_o[PIN_W-1:0] = rx_rdata;
      REG_LVL: begin
        rdata_o[CW-1:0]   = rx_cnt;
        rdata_o[8+CW-1:8] = tx_cnt;
      end
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dio_stream_chk.sv
module dio_stream_chk #(
  parameter int PIN_W      = 12,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic             tick,
  input logic [DIV_W-1:0] cnt,
  input logic             rx_full,
  input logic             tx_empty,
  input logic             ovf,
  input logic             clr_ovf,
  input logic [CW-1:0]    rx_cnt,
  input logic [PIN_W-1:0] pin_o
);
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && !tick |=> cnt == DIV_W'($past(cnt) + 1'b1));

  assert_cnt_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> cnt == '0);

  assert_idle_no_push_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> rx_cnt <= $past(rx_cnt));

  assert_rx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(FIFO_DEPTH));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && rx_full |=> ovf);

  assert_ovf_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf && !clr_ovf |=> ovf);

  assert_unf_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && tx_empty |=> $stable(pin_o));
endmodule

bind dio_stream dio_stream_chk #(
  .PIN_W(PIN_W), .FIFO_DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en_q), .tick(tick), .cnt(cnt),
  .rx_full(rx_full), .tx_empty(tx_empty), .ovf(ovf_q), .clr_ovf(clr_ovf),
  .rx_cnt(rx_cnt), .pin_o(pin_o)
);

// File: tb/dio_stream_test.sv
module dio_stream_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [11:0] pin_i = '0;
  logic [11:0] pin_o, pin_oe;
  bit          rand_pins = 1'b0;
  int          nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dio_stream uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe)
  );

  // behavioural reference
  bit          m_en, m_ovf, m_unf;
  logic [15:0] m_div, m_cnt;
  logic [11:0] m_dir, m_drive, m_s1, m_s2;
  logic [11:0] rxq[$], txq[$];

  task automatic m_reset();
    m_en = 0; m_ovf = 0; m_unf = 0; m_div = 0; m_cnt = 0;
    m_dir = 0; m_drive = 0; m_s1 = 0; m_s2 = 0;
    rxq.delete(); txq.delete();
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      bit tk, rxf, rxe, txf, txe, w, r;
      logic [11:0] samp;
      tk = m_en && (m_cnt == m_div);
      samp = m_s2 & ~m_dir;
      rxf = rxq.size() == 8; rxe = rxq.size() == 0;
      txf = txq.size() == 8; txe = txq.size() == 0;
      w = cs && we; r = cs && !we;
      if (r && addr == 3'd4 && !rxe) void'(rxq.pop_front());
      if (tk && !rxf) rxq.push_back(samp);
      if (tk && !txe) m_drive = txq.pop_front();
      if (w && addr == 3'd5 && !txf) txq.push_back(wdata[11:0]);
      m_ovf = (m_ovf && !(w && addr == 3'd3 && wdata[0])) || (tk && rxf);
      m_unf = (m_unf && !(w && addr == 3'd3 && wdata[1])) || (tk && txe);
      m_cnt = (!m_en || tk) ? 16'd0 : m_cnt + 16'd1;
      if (w && addr == 3'd0) m_en = wdata[0];
      if (w && addr == 3'd1) m_div = wdata;
      if (w && addr == 3'd2) m_dir = wdata[11:0];
      m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  function automatic logic [15:0] m_rdata();
    case (addr)
      3'd0: return {15'd0, m_en};
      3'd1: return m_div;
      3'd2: return {4'd0, m_dir};
      3'd3: return {12'd0, txq.size() == 8, rxq.size() == 0, m_unf, m_ovf};
      3'd4: return rxq.size() == 0 ? 16'd0 : {4'd0, rxq[0]};
      3'd6: return {8'(txq.size()), 8'(rxq.size())};
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(string lbl, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      check("R5 pin_o", pin_o, m_drive);
      check("R5 pin_oe_o", pin_oe, m_dir);
      case (addr)
        3'd3:    check("R4/R6 status", rdata, m_rdata());
        3'd4:    check("R7 rx data", rdata, m_rdata());
        3'd6:    check("R3/R8 level", rdata, m_rdata());
        default: check("R9 rdata", rdata, m_rdata());
      endcase
    end
  end

  task automatic step();
    @(posedge clk); #2;
    if (rand_pins) pin_i = 12'($urandom);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    step(); cs = 1; we = 1; addr = a; wdata = d;
    step(); cs = 0; we = 0; addr = 3'd6;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    step(); cs = 1; we = 0; addr = a; #1 d = rdata;
    step(); cs = 0; addr = 3'd6;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  initial begin
    #1_500_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(2);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 pin_o", pin_o, 0);
    check("R1 pin_oe_o", pin_oe, 0);
    rd_reg(3'd0, v); check("R1 enable", v, 0);
    rd_reg(3'd1, v); check("R1 divider", v, 0);
    rd_reg(3'd2, v); check("R1 direction", v, 0);
    rd_reg(3'd3, v); check("R1 status", v, 16'h0004);

    // mixed directions, paced stream with later underflow
    wr_reg(3'd2, 16'h0F0);
    wr_reg(3'd1, 16'd3);
    wr_reg(3'd5, 16'hAAA);
    wr_reg(3'd5, 16'h555);
    wr_reg(3'd5, 16'h123);
    pin_i = 12'hC3C;
    wr_reg(3'd0, 16'd1);
    idle(24);
    check("R6 pin_o held", pin_o, 12'h123);
    rd_reg(3'd3, v); check("R6 underflow set", v[1], 1);
    rd_reg(3'd4, v); check("R3 masked sample", v, 16'h0C0C);
    wr_reg(3'd0, 16'd0);
    wr_reg(3'd3, 16'h0002);
    rd_reg(3'd3, v); check("R6 underflow cleared", v[1], 0);

    // drain receive fifo at full speed
    step(); cs = 1; we = 0; addr = 3'd4;
    idle(10);
    cs = 0; addr = 3'd6;
    rd_reg(3'd4, v); check("R7 empty read", v, 0);

    // overflow at one tick per cycle with changing pins, direction change
    rand_pins = 1;
    wr_reg(3'd1, 16'd0);
    wr_reg(3'd2, 16'h000);
    wr_reg(3'd0, 16'd1);
    idle(4);
    wr_reg(3'd2, 16'hF00);
    idle(10);
    wr_reg(3'd0, 16'd0);
    rd_reg(3'd3, v); check("R4 overflow set", v[0], 1);
    rd_reg(3'd6, v); check("R3 rx full level", v[7:0], 8);
    wr_reg(3'd3, 16'h0001);
    rd_reg(3'd3, v); check("R4 overflow cleared", v[0], 0);

    // disabled: no traffic despite pin activity
    idle(20);
    rd_reg(3'd6, v); check("R2 disabled no push", v[7:0], 8);

    // clear while a tick overflows: set wins
    wr_reg(3'd0, 16'd1);
    wr_reg(3'd3, 16'h0001);
    wr_reg(3'd0, 16'd0);
    rd_reg(3'd3, v); check("R4 set beats clear", v[0], 1);
    wr_reg(3'd3, 16'h0003);

    // drain and overfill the transmit fifo while paused
    step(); cs = 1; we = 0; addr = 3'd4;
    idle(9);
    cs = 0; addr = 3'd6;
    for (int i = 0; i < 10; i++) wr_reg(3'd5, 16'(12'h101 * (i + 1)));
    rd_reg(3'd6, v); check("R8 tx full level", v[15:8], 8);
    rd_reg(3'd3, v); check("R8 tx full flag", v[3], 1);

    // stream out at divider 2, outputs enabled at run time
    wr_reg(3'd2, 16'hFFF);
    wr_reg(3'd1, 16'd2);
    wr_reg(3'd0, 16'd1);
    idle(12);
    wr_reg(3'd2, 16'h00F);
    idle(30);
    check("R5 last word", pin_o, 12'h808);
    rd_reg(3'd1, v); check("R9 divider", v, 2);
    rd_reg(3'd0, v); check("R2 enable", v, 1);
    wr_reg(3'd0, 16'd0);
    rand_pins = 0;
    idle(4);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule